// File: doc/BRIEF.md
# Message-Dispatch Interrupt Controller

This block collects eleven interrupt lines and delivers each new event as a single 32-bit memory write. Lines 0 to 5 carry the four shared expansion-bus interrupts and two more of the same kind. Line 6 is an external bus interrupt, line 7 a bus-error line, line 8 keyboard/mouse and line 10 the serial port. Line 9 is unused. An expansion-bus card in slot S is wired to line (S AND 3).

The block keeps a register of the current level of every line. A low-to-high change on a line is an event. Every event sets a sticky pending bit. An event on an enabled line is also queued for dispatch. A control register puts each line into group 0 or group 1. Each group has a target register. One value holds both the write address, in its upper bits, and the write data, in its low five bits.

Dispatches leave through a valid/ready port. While one write is outstanding, new events wait in a per-line queue. The queue is served from the lowest line number up. A timeout-command address register and two read-only request views complete the register set.

Top module: `irq_msg_dispatch`

## Requirements
- R1: The level register holds the line inputs as they were one clock earlier. Writes to it (byte offset 0x14) have no effect.
- R2: A line that rises sets its bit in the pending register (offset 0x10). A line that stays high creates no further event after pending has been cleared.
- R3: A pending-register read returns the value before the access and clears the register. A write clears it whatever the data. An event in the same cycle as either access survives in pending.
- R4: An event on a line whose enable bit (mask, offset 0x08) is set produces one dispatch. An event on a disabled line produces none.
- R5: The dispatch uses target 1 (offset 0x04) when the line's control bit (offset 0x0C) is 1, and target 0 (offset 0x00) when it is 0.
- R6: The dispatch address is the chosen target with bits 4:0 cleared. The dispatch data is bits 4:0 of that target, zero-extended.
- R7: Once valid is raised, it stays high with address and data unchanged until a cycle with ready high. Valid drops after that cycle.
- R8: Events queued while a dispatch is outstanding are issued one at a time, lowest line number first.
- R9: Request view 0 (offset 0x18) reads level AND mask AND NOT control. Request view 1 (offset 0x1C) reads level AND mask AND control. Writes to either view have no effect.
- R10: The timeout-command register (offset 0x20) resets to 0xFFFA0030. A write stores 0xFFFA0030 ORed with bits 16:13 of the data.
- R11: After reset, targets, mask, control, pending and valid are zero. Any unmapped offset reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | 11 | Interrupt line levels |
| regAddr | input | 8 | Register byte address; bits 1:0 ignored |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data, valid the cycle after the read strobe |
| dispValid | output | 1 | Dispatch write request |
| dispReady | input | 1 | Dispatch accepted |
| dispAddr | output | 32 | Dispatch write address |
| dispData | output | 32 | Dispatch write data |

## Verification
The embedded properties check the following on every cycle:
- the level register follows the lines (R1);
- every event lands in pending (R2);
- a pending access leaves only that cycle's events (R3);
- no event is queued on a disabled line (R4);
- valid is held until it is accepted (R7).

Group selection, target splitting and lowest-first ordering are only seen in the bench's scenarios. So are the read-then-clear value, the ignored writes and the timeout-command encoding. Each scenario compares the dispatched address and data, or a read-back, against values worked out from the requirements.

// File: rtl/irqmsg_pkg.sv
package irqmsg_pkg;

  typedef enum logic [3:0] {
    SEL_TGT0  = 4'd0,
    SEL_TGT1  = 4'd1,
    SEL_MASK  = 4'd2,
    SEL_CTRL  = 4'd3,
    SEL_PEND  = 4'd4,
    SEL_LEVEL = 4'd5,
    SEL_VIEW0 = 4'd6,
    SEL_VIEW1 = 4'd7,
    SEL_TOC   = 4'd8,
    SEL_NONE  = 4'd15
  } regSel_e;

  typedef struct packed {
    logic    wrTgt0;
    logic    wrTgt1;
    logic    wrMask;
    logic    wrCtrl;
    logic    wrToc;
    logic    pendClr;
    logic    rdEn;
    logic    launch;
    regSel_e rdSel;
  } ctrlStrobes_t;

  localparam logic [31:0] TOC_BASE = 32'hFFFA0030;
  localparam logic [31:0] TOC_KEEP = 32'h0001E000;

endpackage

// File: rtl/irqmsg_ctrl.sv
module irqmsg_ctrl
  import irqmsg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              queueAny,
  input  logic              dispReady,
  output ctrlStrobes_t      strobes,
  output logic              dispValid
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  regSel_e          sel;

  always_comb begin
    wordIdx = regAddr[ADDR_W-1:2];
    sel     = SEL_NONE;
    if (wordIdx <= IDX_W'(8)) sel = regSel_e'(wordIdx[3:0]);
  end

  always_comb begin
    strobes.wrTgt0  = regWrEn && (sel == SEL_TGT0);
    strobes.wrTgt1  = regWrEn && (sel == SEL_TGT1);
    strobes.wrMask  = regWrEn && (sel == SEL_MASK);
    strobes.wrCtrl  = regWrEn && (sel == SEL_CTRL);
    strobes.wrToc   = regWrEn && (sel == SEL_TOC);
    strobes.pendClr = (regWrEn || regRdEn) && (sel == SEL_PEND);
    strobes.rdEn    = regRdEn;
    strobes.rdSel   = sel;
    strobes.launch  = !dispValid && queueAny;
  end

  // one outstanding write; valid drops on acceptance
  always_ff @(posedge clk) begin
    if (!rstN)               dispValid <= 1'b0;
    else if (strobes.launch) dispValid <= 1'b1;
    else if (dispReady)      dispValid <= 1'b0;
  end

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && !dispReady |=> dispValid);

  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && dispReady |=> !dispValid);

endmodule

// File: rtl/irqmsg_datapath.sv
module irqmsg_datapath
  import irqmsg_pkg::*;
#(
  parameter int NUM_LINES = 11,
  parameter int DATA_W    = 32,
  parameter int OFS_W     = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [DATA_W-1:0]    regWrData,
  input  ctrlStrobes_t         strobes,
  output logic                 queueAny,
  output logic [DATA_W-1:0]    regRdData,
  output logic [DATA_W-1:0]    dispAddr,
  output logic [DATA_W-1:0]    dispData
);

  logic [DATA_W-1:0]    tgt0, tgt1, tocReg, chosenTgt;
  logic [NUM_LINES-1:0] maskReg, ctrlReg, pendReg, levelReg, queueReg;
  logic [NUM_LINES-1:0] riseVec, pickVec;
  logic                 pickGrp1;

  assign riseVec  = irqLines & ~levelReg;
  assign pickVec  = queueReg & (~queueReg + NUM_LINES'(1));
  assign pickGrp1 = |(pickVec & ctrlReg);
  assign queueAny = |queueReg;
  assign chosenTgt = pickGrp1 ? tgt1 : tgt0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgt0     <= '0;
      tgt1     <= '0;
      maskReg  <= '0;
      ctrlReg  <= '0;
      tocReg   <= TOC_BASE;
      levelReg <= '0;
    end else begin
      levelReg <= irqLines;
      if (strobes.wrTgt0) tgt0    <= regWrData;
      if (strobes.wrTgt1) tgt1    <= regWrData;
      if (strobes.wrMask) maskReg <= regWrData[NUM_LINES-1:0];
      if (strobes.wrCtrl) ctrlReg <= regWrData[NUM_LINES-1:0];
      if (strobes.wrToc)  tocReg  <= TOC_BASE | (regWrData & TOC_KEEP);
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendReg[i]  <= 1'b0;
        queueReg[i] <= 1'b0;
      end else begin
        // a new event beats a same-cycle clear
        if (riseVec[i])           pendReg[i] <= 1'b1;
        else if (strobes.pendClr) pendReg[i] <= 1'b0;
        if (riseVec[i] && maskReg[i])           queueReg[i] <= 1'b1;
        else if (strobes.launch && pickVec[i])  queueReg[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispAddr <= '0;
      dispData <= '0;
    end else if (strobes.launch) begin
      dispAddr <= {chosenTgt[DATA_W-1:OFS_W], OFS_W'(0)};
      dispData <= DATA_W'(chosenTgt[OFS_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) regRdData <= '0;
    else if (strobes.rdEn) begin
      case (strobes.rdSel)
        SEL_TGT0:  regRdData <= tgt0;
        SEL_TGT1:  regRdData <= tgt1;
        SEL_MASK:  regRdData <= DATA_W'(maskReg);
        SEL_CTRL:  regRdData <= DATA_W'(ctrlReg);
        SEL_PEND:  regRdData <= DATA_W'(pendReg);
        SEL_LEVEL: regRdData <= DATA_W'(levelReg);
        SEL_VIEW0: regRdData <= DATA_W'(levelReg & maskReg & ~ctrlReg);
        SEL_VIEW1: regRdData <= DATA_W'(levelReg & maskReg & ctrlReg);
        SEL_TOC:   regRdData <= tocReg;
        default:   regRdData <= '0;
      endcase
    end
  end

  // R1
  level_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> levelReg == $past(irqLines));

  // R2
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    |riseVec |=> (pendReg & $past(riseVec)) == $past(riseVec));

  // R3
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pendClr |=> pendReg == $past(riseVec));

  // R4
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (queueReg == '0) && ((riseVec & maskReg) == '0) |=> queueReg == '0);

endmodule

// File: rtl/irq_msg_dispatch.sv
module irq_msg_dispatch
  import irqmsg_pkg::*;
#(
  parameter int NUM_LINES = 11,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int OFS_W     = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 dispValid,
  input  logic                 dispReady,
  output logic [DATA_W-1:0]    dispAddr,
  output logic [DATA_W-1:0]    dispData
);

  ctrlStrobes_t strobes;
  logic         queueAny;

  irqmsg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .queueAny(queueAny), .dispReady(dispReady),
    .strobes(strobes), .dispValid(dispValid)
  );

  irqmsg_datapath #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_dp (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .regWrData(regWrData),
    .strobes(strobes), .queueAny(queueAny), .regRdData(regRdData),
    .dispAddr(dispAddr), .dispData(dispData)
  );

endmodule

// File: tb/sim_irq_msg_dispatch.sv
module sim_irq_msg_dispatch;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_TGT0 = 8'h00, A_TGT1 = 8'h04, A_MASK = 8'h08,
                         A_CTRL = 8'h0C, A_PEND = 8'h10, A_LEVEL = 8'h14,
                         A_VIEW0 = 8'h18, A_VIEW1 = 8'h1C, A_TOC = 8'h20;
  localparam logic [31:0] T0 = 32'h10000043, T1 = 32'h200007FF;

  typedef struct packed {
    logic [3:0]  line;
    logic [10:0] ctrlVal;
    logic [31:0] expAddr;
    logic [31:0] expData;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{4'd0,  11'h000, 32'h10000040, 32'd3},
    '{4'd6,  11'h040, 32'h200007E0, 32'd31},
    '{4'd10, 11'h400, 32'h200007E0, 32'd31},
    '{4'd7,  11'h400, 32'h10000040, 32'd3},
    '{4'd3,  11'h7FF, 32'h200007E0, 32'd31}
  };

  logic        clk = 1'b0, rstN = 1'b0;
  logic [10:0] irqLines = '0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0, dispReady = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData, dispAddr, dispData;
  logic        dispValid;
  int          total = 0, fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_msg_dispatch u0 (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .regAddr(regAddr),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regWrData(regWrData),
    .regRdData(regRdData), .dispValid(dispValid), .dispReady(dispReady),
    .dispAddr(dispAddr), .dispData(dispData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic pulse(input logic [10:0] bits);
    irqLines = irqLines | bits;
    @(negedge clk);
    irqLines = irqLines & ~bits;
  endtask

  task automatic waitValid();
    for (int k = 0; k < 20 && !dispValid; k++) @(negedge clk);
  endtask

  task automatic accept();
    dispReady = 1'b1;
    @(negedge clk);
    dispReady = 1'b0;
    chk("R7 valid drops after ready", 32'(dispValid), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, holdAddr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 valid after reset", 32'(dispValid), 32'd0);
    regRead(A_PEND, d);  chk("R11 pending reset", d, 32'd0);
    regRead(A_MASK, d);  chk("R11 mask reset", d, 32'd0);
    regRead(A_TGT1, d);  chk("R11 target1 reset", d, 32'd0);
    regRead(A_TOC, d);   chk("R10 timeout reg reset", d, 32'hFFFA0030);
    regRead(8'h40, d);   chk("R11 unmapped read", d, 32'd0);

    regWrite(A_TGT0, T0);
    regWrite(A_TGT1, T1);
    regWrite(A_MASK, 32'h7FF);

    // R4 R5 R6 vector table
    foreach (VECS[n]) begin
      regWrite(A_CTRL, 32'(VECS[n].ctrlVal));
      pulse(11'd1 << VECS[n].line);
      waitValid();
      chk("R4 dispatch raised", 32'(dispValid), 32'd1);
      chk("R5 R6 dispatch address", dispAddr, VECS[n].expAddr);
      chk("R6 dispatch data", dispData, VECS[n].expData);
      accept();
      regWrite(A_PEND, 32'd0);
    end

    // R7 hold while not ready
    regWrite(A_CTRL, 32'd0);
    pulse(11'h002);
    waitValid();
    holdAddr = dispAddr;
    repeat (3) @(negedge clk);
    chk("R7 valid held", 32'(dispValid), 32'd1);
    chk("R7 address stable", dispAddr, holdAddr);
    accept();

    // R8 lowest line first: line 2 in group 1, line 5 in group 0
    regWrite(A_CTRL, 32'h004);
    pulse(11'h024);
    waitValid();
    chk("R8 first served line 2", dispAddr, 32'h200007E0);
    accept();
    waitValid();
    chk("R8 second served line 5", dispAddr, 32'h10000040);
    accept();
    repeat (3) @(negedge clk);
    chk("R8 no extra dispatch", 32'(dispValid), 32'd0);

    // R4 disabled line, R2 pending set, R3 read clears
    regWrite(A_MASK, 32'd0);
    regWrite(A_PEND, 32'd0);
    pulse(11'h100);
    repeat (5) @(negedge clk);
    chk("R4 masked line no dispatch", 32'(dispValid), 32'd0);
    regRead(A_PEND, d);  chk("R2 pending set by edge", d, 32'h100);
    regRead(A_PEND, d);  chk("R3 read cleared pending", d, 32'd0);

    // R2 line held high: no new event
    irqLines[3] = 1'b1;
    repeat (2) @(negedge clk);
    regWrite(A_PEND, 32'h0);
    repeat (3) @(negedge clk);
    regRead(A_PEND, d);  chk("R2 held line no new event", d, 32'd0);
    irqLines[3] = 1'b0;
    @(negedge clk);

    // R3 same-cycle edge wins
    pulse(11'h002);
    regAddr = A_PEND; regRdEn = 1'b1; irqLines[4] = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0; irqLines[4] = 1'b0;
    chk("R3 read returns old value", regRdData, 32'h002);
    regRead(A_PEND, d);  chk("R3 same-cycle edge kept", d, 32'h010);
    pulse(11'h001);
    regWrite(A_PEND, 32'h7FF);
    regRead(A_PEND, d);  chk("R3 write clears pending", d, 32'd0);

    // R9 request views and R1 level register
    irqLines = 11'h02F;
    repeat (2) @(negedge clk);
    regWrite(A_MASK, 32'h00F);
    regWrite(A_CTRL, 32'h005);
    regRead(A_VIEW0, d); chk("R9 view0", d, 32'h00A);
    regRead(A_VIEW1, d); chk("R9 view1", d, 32'h005);
    regWrite(A_VIEW0, 32'h7FF);
    regWrite(A_VIEW1, 32'h000);
    regRead(A_VIEW0, d); chk("R9 view0 write ignored", d, 32'h00A);
    regRead(A_VIEW1, d); chk("R9 view1 write ignored", d, 32'h005);
    regRead(A_LEVEL, d); chk("R1 level mirrors lines", d, 32'h02F);
    regWrite(A_LEVEL, 32'h000);
    regRead(A_LEVEL, d); chk("R1 level write ignored", d, 32'h02F);
    chk("R4 no dispatch from mask set late", 32'(dispValid), 32'd0);
    irqLines = '0;
    repeat (2) @(negedge clk);
    regRead(A_LEVEL, d); chk("R1 level follows fall", d, 32'h000);

    // R10 timeout-command register
    regWrite(A_TOC, 32'hFFFFFFFF);
    regRead(A_TOC, d);   chk("R10 keep bits 16:13", d, 32'hFFFBE030);
    regWrite(A_TOC, 32'h00000000);
    regRead(A_TOC, d);   chk("R10 constant only", d, 32'hFFFA0030);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule